// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This block carries out the single-bit instruction group of a small 4-bit controller core. Each instruction selects one bit of one nibble in data memory. It can force that bit high or low, test it and ask the sequencer to skip the next instruction, test it and clear it in one step, or merge it into the carry flag with AND, OR or XOR. The sequencer hands over the operation code, an addressing mode, the address and bit fields of the instruction, the current H and L index registers and the carry flag, then pulses `start`.

The unit forms the nibble address and the bit number from the chosen mode. It reads the nibble through a synchronous data-memory port and computes the result. When the operation needs it, it writes the nibble back with only the addressed bit changed. Every instruction takes exactly two clock cycles, closed by a one-cycle `done`. The skip request and the new carry are valid during that `done` cycle. The sequencer must add its own extra cycles when the skip is taken, and it must load the carry it sees on `cy_out` during `done`.

Top module: `bitop_unit`

## Requirements
- R1: After `start` is sampled high while idle, `mem_rd_en` is high for the next cycle only. `done` is high in the cycle after that, and is low again in the following cycle.
- R2: A `start` seen while an instruction is in progress is ignored. The fields captured at acceptance govern the whole instruction, even if the inputs change mid-instruction.
- R3: Mode 0 (direct) uses `fld_addr` as the nibble address and `fld_bit` as the bit number.
- R4: Mode 1 (fixed region) addresses page 0xB when `fld_addr[4]` is 0 and page 0xF when it is 1. The low address nibble is `fld_addr[3:0]`, and the bit number is `fld_bit`.
- R5: Mode 2 (L-indexed) forms the address from `fld_addr[7:2]` as its upper six bits and `reg_l[3:2]` as its lower two bits. The bit number is `reg_l[1:0]`.
- R6: Mode 3 (H-indexed) forms the address from `reg_h` as its upper nibble and `fld_addr[3:0]` as its lower nibble. The bit number is `fld_bit`.
- R7: Op 0 (set) and op 1 (clear) write the nibble back to the same address in the `done` cycle. The addressed bit is forced to 1 or 0 and the other three bits are unchanged.
- R8: Op 2 raises `skip` with `done` when the bit is 1, and op 3 does so when the bit is 0. Neither writes memory.
- R9: Op 4 (test and clear) raises `skip` and writes the nibble with the bit cleared when the bit is 1. When the bit is 0 it does neither.
- R10: Ops 5, 6 and 7 drive `cy_out` in the `done` cycle with `cy_in` AND, OR or XOR the bit, and write nothing. For every other op, `cy_out` equals the captured `cy_in`.
- R11: Ops 4 to 7 combined with mode 0 are not allowed. Such an instruction still completes in two cycles, but it writes nothing, raises no skip and leaves the carry as captured.
- R12: While reset is applied, `mem_rd_en`, `mem_wr_en`, `done`, `skip` and `cy_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| op | input | 3 | Operation: 0 set, 1 clear, 2 skip-if-1, 3 skip-if-0, 4 skip-if-1-and-clear, 5 AND, 6 OR, 7 XOR |
| mode | input | 2 | Addressing: 0 direct, 1 fixed region, 2 L-indexed, 3 H-indexed |
| fld_addr | input | 8 | Address field of the instruction |
| fld_bit | input | 2 | Bit-number field of the instruction |
| reg_h | input | 4 | H index register |
| reg_l | input | 4 | L index register |
| cy_in | input | 1 | Current carry flag |
| mem_addr | output | 8 | Data-memory nibble address |
| mem_rd_en | output | 1 | Read strobe, data returned the next cycle |
| mem_rdata | input | 4 | Read data from memory |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 4 | Write data |
| done | output | 1 | Final execution cycle of an instruction |
| skip | output | 1 | Skip request, valid with done |
| cy_out | output | 1 | Updated carry, valid with done |

## Verification
Each of the four addressing modes is driven with field values whose bits differ from one another. In the L-indexed case, for example, `reg_l` has a different value in its address half and its bit half, so swapped or shifted slices show up as a wrong address or a wrong bit. Set and clear run on nibbles whose other bits are mixed, which exposes writes that touch neighbouring bits. The skip tests run on a bit that is known to be 1 and then 0, so the sense of each test is checked both ways. Test-and-clear is run twice on the same bit, so the first run shows skip with clear and the second shows neither. The carry ops cover carry and bit values in several combinations, which separates AND, OR and XOR. The forbidden mode combinations and a `start` held during a busy instruction show that nothing outside the accepted instruction changes memory, skip or carry.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [2:0] {
    OP_SET  = 3'd0,
    OP_CLR  = 3'd1,
    OP_SKT  = 3'd2,
    OP_SKF  = 3'd3,
    OP_SKTC = 3'd4,
    OP_AND  = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } bop_e;

  typedef enum logic [1:0] {
    AM_DIR = 2'd0,
    AM_FIX = 2'd1,
    AM_LIX = 2'd2,
    AM_HIX = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_READ = 2'd1,
    PH_EXEC = 2'd2
  } phase_e;

  function automatic logic is_cy_op(input bop_e o);
    return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
  endfunction

  // direct mode accepts only set, clear and the plain skip tests
  function automatic logic mode_allowed(input bop_e o, input amode_e m);
    return !((m == AM_DIR) && ((o == OP_SKTC) || is_cy_op(o)));
  endfunction

endpackage

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 4,
  localparam int BIW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  bop_e           op_i,
  input  amode_e         mode_i,
  input  logic [AW-1:0]  fa_i,
  input  logic [BIW-1:0] fb_i,
  input  logic [DW-1:0]  h_i,
  input  logic [DW-1:0]  l_i,
  input  logic           cy_i,
  output bop_e           op_q,
  output amode_e         mode_q,
  output logic [AW-1:0]  fa_q,
  output logic [BIW-1:0] fb_q,
  output logic [DW-1:0]  h_q,
  output logic [DW-1:0]  l_q,
  output logic           cy_q,
  output logic           rd_phase,
  output logic           ex_phase
);

  phase_e ph_q, ph_d;
  logic   accept;

  assign accept = start && (ph_q == PH_IDLE);

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (accept) ph_d = PH_READ;
      PH_READ: ph_d = PH_EXEC;
      PH_EXEC: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  // operand capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_SET;
      mode_q <= AM_DIR;
      fa_q   <= '0;
      fb_q   <= '0;
      h_q    <= '0;
      l_q    <= '0;
      cy_q   <= 1'b0;
    end else if (accept) begin
      op_q   <= op_i;
      mode_q <= mode_i;
      fa_q   <= fa_i;
      fb_q   <= fb_i;
      h_q    <= h_i;
      l_q    <= l_i;
      cy_q   <= cy_i;
    end
  end

  assign rd_phase = (ph_q == PH_READ);
  assign ex_phase = (ph_q == PH_EXEC);

  // R1
  read_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |=> ex_phase);

  // R1
  exec_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_phase |=> !ex_phase && !rd_phase);

  // R2
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && start) |=> (op_q == $past(op_q)) && (fa_q == $past(fa_q)));

endmodule

// File: rtl/bitop_agen.sv
module bitop_agen
  import bitop_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 4,
  parameter logic [AW-DW-1:0] FIX_LO_PAGE = 'hB,
  parameter logic [AW-DW-1:0] FIX_HI_PAGE = 'hF,
  localparam int BIW = $clog2(DW),
  localparam int LX_W = DW - BIW
) (
  input  amode_e         mode,
  input  logic [AW-1:0]  fa,
  input  logic [BIW-1:0] fb,
  input  logic [DW-1:0]  h,
  input  logic [DW-1:0]  l,
  output logic [AW-1:0]  addr,
  output logic [BIW-1:0] bitn
);

  always_comb begin
    addr = fa;
    bitn = fb;
    case (mode)
      AM_DIR: begin
        addr = fa;
        bitn = fb;
      end
      AM_FIX: begin
        addr = {(fa[DW] ? FIX_HI_PAGE : FIX_LO_PAGE), fa[DW-1:0]};
        bitn = fb;
      end
      AM_LIX: begin
        addr = {fa[AW-1:LX_W], l[DW-1:BIW]};
        bitn = l[BIW-1:0];
      end
      AM_HIX: begin
        addr = {h, fa[AW-DW-1:0]};
        bitn = fb;
      end
      default: begin
        addr = fa;
        bitn = fb;
      end
    endcase
  end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DW = 4,
  localparam int BIW = $clog2(DW)
) (
  input  bop_e           op,
  input  logic           legal,
  input  logic [BIW-1:0] bitn,
  input  logic [DW-1:0]  rdata,
  input  logic           cy,
  output logic [DW-1:0]  wdata,
  output logic           wr_req,
  output logic           skip_req,
  output logic           cy_new
);

  logic bitv;
  logic new_bit;

  assign bitv = rdata[bitn];

  always_comb begin
    wr_req   = 1'b0;
    skip_req = 1'b0;
    new_bit  = bitv;
    cy_new   = cy;
    case (op)
      OP_SET: begin
        wr_req  = 1'b1;
        new_bit = 1'b1;
      end
      OP_CLR: begin
        wr_req  = 1'b1;
        new_bit = 1'b0;
      end
      OP_SKT:  skip_req = bitv;
      OP_SKF:  skip_req = !bitv;
      OP_SKTC: begin
        skip_req = legal && bitv;
        wr_req   = legal && bitv;
        new_bit  = 1'b0;
      end
      OP_AND:  if (legal) cy_new = cy & bitv;
      OP_OR:   if (legal) cy_new = cy | bitv;
      OP_XOR:  if (legal) cy_new = cy ^ bitv;
      default: ;
    endcase
  end

  for (genvar i = 0; i < DW; i++) begin : g_merge
    assign wdata[i] = (bitn == BIW'(i)) ? new_bit : rdata[i];
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 4,
  localparam int BIW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic [1:0]     mode,
  input  logic [AW-1:0]  fld_addr,
  input  logic [BIW-1:0] fld_bit,
  input  logic [DW-1:0]  reg_h,
  input  logic [DW-1:0]  reg_l,
  input  logic           cy_in,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd_en,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_wr_en,
  output logic [DW-1:0]  mem_wdata,
  output logic           done,
  output logic           skip,
  output logic           cy_out
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  bop_e           op_q;
  amode_e         mode_q;
  logic [AW-1:0]  fa_q;
  logic [BIW-1:0] fb_q;
  logic [DW-1:0]  h_q, l_q;
  logic           cy_q;
  logic           rd_phase, ex_phase;
  logic [AW-1:0]  addr;
  logic [BIW-1:0] bitn;
  logic           legal;
  logic           wr_req, skip_req, cy_new;
  logic [DW-1:0]  wdata;

  bitop_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .op_i     (bop_e'(op)),
    .mode_i   (amode_e'(mode)),
    .fa_i     (fld_addr),
    .fb_i     (fld_bit),
    .h_i      (reg_h),
    .l_i      (reg_l),
    .cy_i     (cy_in),
    .op_q     (op_q),
    .mode_q   (mode_q),
    .fa_q     (fa_q),
    .fb_q     (fb_q),
    .h_q      (h_q),
    .l_q      (l_q),
    .cy_q     (cy_q),
    .rd_phase (rd_phase),
    .ex_phase (ex_phase)
  );

  bitop_agen #(.AW(AW), .DW(DW)) u_agen (
    .mode (mode_q),
    .fa   (fa_q),
    .fb   (fb_q),
    .h    (h_q),
    .l    (l_q),
    .addr (addr),
    .bitn (bitn)
  );

  assign legal = mode_allowed(op_q, mode_q);

  bitop_alu #(.DW(DW)) u_alu (
    .op       (op_q),
    .legal    (legal),
    .bitn     (bitn),
    .rdata    (mem_rdata),
    .cy       (cy_q),
    .wdata    (wdata),
    .wr_req   (wr_req),
    .skip_req (skip_req),
    .cy_new   (cy_new)
  );

  assign mem_addr  = addr;
  assign mem_rd_en = rd_phase;
  assign mem_wr_en = ex_phase && wr_req;
  assign mem_wdata = wdata;
  assign done      = ex_phase;
  assign skip      = ex_phase && skip_req;
  assign cy_out    = ex_phase ? cy_new : cy_q;

  // R7
  wr_addr_held_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_en |-> (mem_addr == $past(mem_addr)) && $past(mem_rd_en));

  // R7
  one_bit_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_en |-> $countones(mem_wdata ^ mem_rdata) <= 1);

  // R8
  skip_with_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    skip |-> done);

  // R8
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && ((op_q == OP_SKT) || (op_q == OP_SKF))) |-> !mem_wr_en);

  // R10
  cy_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !is_cy_op(op_q)) |-> (cy_out == cy_q));

  // R11
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && (mode_q == AM_DIR) && (op_q == OP_SKTC || is_cy_op(op_q)))
      |-> (!mem_wr_en && !skip && (cy_out == cy_q)));

  // R1
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_rd_en && (mem_wr_en || done)));

endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
  localparam int AW = 8;
  localparam int DW = 4;
  localparam int BIW = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [2:0]     op;
  logic [1:0]     mode;
  logic [AW-1:0]  fld_addr;
  logic [BIW-1:0] fld_bit;
  logic [DW-1:0]  reg_h, reg_l;
  logic           cy_in;
  logic [AW-1:0]  mem_addr;
  logic           mem_rd_en, mem_wr_en;
  logic [DW-1:0]  mem_rdata, mem_wdata;
  logic           done, skip, cy_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bitop_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode),
    .fld_addr(fld_addr), .fld_bit(fld_bit), .reg_h(reg_h), .reg_l(reg_l),
    .cy_in(cy_in), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .done(done), .skip(skip), .cy_out(cy_out)
  );

  // synchronous data memory model
  logic [DW-1:0] mem [0:(1<<AW)-1];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) mem[i] <= DW'(i * 7 + 3);
      mem_rdata <= '0;
    end else begin
      if (mem_wr_en) mem[mem_addr] <= mem_wdata;
      if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // one instruction with full expectation, optionally holding start busy
  task automatic run_op(input logic [2:0] o, input logic [1:0] m, input logic [7:0] fa,
                        input logic [1:0] fb, input logic [3:0] h, input logic [3:0] l,
                        input logic cy, input string tag, input bit hold);
    logic [7:0] ea;
    logic [1:0] eb;
    logic [3:0] old, enew;
    logic bv, ok, e_wr, e_skip, e_cy;
    ea = fa; eb = fb;
    case (m)
      2'd1: ea = {(fa[4] ? 4'hF : 4'hB), fa[3:0]};
      2'd2: begin ea = {fa[7:2], l[3:2]}; eb = l[1:0]; end
      2'd3: ea = {h, fa[3:0]};
      default: ;
    endcase
    old = mem[ea];
    bv = old[eb];
    ok = !(m == 2'd0 && o >= 3'd4);
    enew = old; e_wr = 0; e_skip = 0; e_cy = cy;
    case (o)
      3'd0: begin e_wr = 1; enew[eb] = 1'b1; end
      3'd1: begin e_wr = 1; enew[eb] = 1'b0; end
      3'd2: e_skip = bv;
      3'd3: e_skip = !bv;
      3'd4: if (ok && bv) begin e_skip = 1; e_wr = 1; enew[eb] = 1'b0; end
      3'd5: if (ok) e_cy = cy & bv;
      3'd6: if (ok) e_cy = cy | bv;
      default: if (ok) e_cy = cy ^ bv;
    endcase
    @(negedge clk);
    op = o; mode = m; fld_addr = fa; fld_bit = fb; reg_h = h; reg_l = l; cy_in = cy;
    start = 1'b1;
    @(negedge clk);
    if (hold) begin
      op = 3'd1; fld_addr = ~fa; fld_bit = ~fb; reg_h = ~h; reg_l = ~l; cy_in = ~cy;
    end else start = 1'b0;
    chk("R1", "rd_en first cycle", int'(mem_rd_en), 1);
    chk("R1", "done early", int'(done), 0);
    chk(tag, "address", int'(mem_addr), int'(ea));
    @(negedge clk);
    start = 1'b0;
    chk("R1", "done", int'(done), 1);
    chk("R1", "rd_en in done", int'(mem_rd_en), 0);
    chk(tag, "skip", int'(skip), int'(e_skip));
    chk(tag, "cy_out", int'(cy_out), int'(e_cy));
    chk(tag, "wr_en", int'(mem_wr_en), int'(e_wr));
    if (e_wr) chk(tag, "wdata", int'(mem_wdata), int'(enew));
    @(negedge clk);
    chk("R1", "done cleared", int'(done), 0);
    chk(tag, "rd_en after done", int'(mem_rd_en), 0);
    chk(tag, "memory nibble", int'(mem[ea]), int'(enew));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 0; op = 0; mode = 0; fld_addr = 0; fld_bit = 0;
    reg_h = 0; reg_l = 0; cy_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", "rd_en", int'(mem_rd_en), 0);
    chk("R12", "wr_en", int'(mem_wr_en), 0);
    chk("R12", "done", int'(done), 0);
    chk("R12", "skip", int'(skip), 0);
    chk("R12", "cy_out", int'(cy_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_direct();
    run_op(3'd0, 2'd0, 8'h23, 2'd2, 4'h0, 4'h0, 1'b0, "R3", 0);
    run_op(3'd1, 2'd0, 8'h23, 2'd0, 4'h0, 4'h0, 1'b0, "R7", 0);
    run_op(3'd0, 2'd0, 8'h6A, 2'd3, 4'h0, 4'h0, 1'b1, "R7", 0);
  endtask

  task automatic t_skip();
    run_op(3'd0, 2'd0, 8'h41, 2'd1, 4'h0, 4'h0, 1'b0, "R7", 0);
    run_op(3'd2, 2'd0, 8'h41, 2'd1, 4'h0, 4'h0, 1'b0, "R8", 0);
    run_op(3'd3, 2'd0, 8'h41, 2'd1, 4'h0, 4'h0, 1'b1, "R8", 0);
    run_op(3'd1, 2'd0, 8'h41, 2'd1, 4'h0, 4'h0, 1'b0, "R7", 0);
    run_op(3'd3, 2'd0, 8'h41, 2'd1, 4'h0, 4'h0, 1'b0, "R8", 0);
    run_op(3'd2, 2'd0, 8'h41, 2'd1, 4'h0, 4'h0, 1'b1, "R8", 0);
  endtask

  task automatic t_fixed();
    run_op(3'd0, 2'd1, 8'h05, 2'd3, 4'h0, 4'h0, 1'b0, "R4", 0);
    run_op(3'd1, 2'd1, 8'h1A, 2'd0, 4'h0, 4'h0, 1'b0, "R4", 0);
    run_op(3'd4, 2'd1, 8'h05, 2'd3, 4'h0, 4'h0, 1'b0, "R4", 0);
  endtask

  task automatic t_lindex();
    run_op(3'd0, 2'd2, 8'h5C, 2'd0, 4'h0, 4'hD, 1'b0, "R5", 0);
    run_op(3'd2, 2'd2, 8'h5C, 2'd3, 4'h0, 4'hD, 1'b0, "R5", 0);
    run_op(3'd1, 2'd2, 8'hA3, 2'd1, 4'h0, 4'h6, 1'b0, "R5", 0);
  endtask

  task automatic t_hindex();
    run_op(3'd0, 2'd3, 8'h04, 2'd3, 4'h9, 4'h0, 1'b0, "R6", 0);
    run_op(3'd4, 2'd3, 8'h04, 2'd3, 4'h9, 4'h0, 1'b0, "R9", 0);
    run_op(3'd4, 2'd3, 8'h04, 2'd3, 4'h9, 4'h0, 1'b0, "R9", 0);
    run_op(3'd2, 2'd3, 8'h04, 2'd3, 4'h9, 4'h0, 1'b0, "R9", 0);
  endtask

  task automatic t_carry();
    run_op(3'd0, 2'd3, 8'h07, 2'd2, 4'h3, 4'h0, 1'b0, "R7", 0);
    run_op(3'd5, 2'd3, 8'h07, 2'd2, 4'h3, 4'h0, 1'b1, "R10", 0);
    run_op(3'd5, 2'd3, 8'h07, 2'd2, 4'h3, 4'h0, 1'b0, "R10", 0);
    run_op(3'd6, 2'd1, 8'h12, 2'd0, 4'h0, 4'h0, 1'b0, "R10", 0);
    run_op(3'd7, 2'd3, 8'h07, 2'd2, 4'h3, 4'h0, 1'b1, "R10", 0);
    run_op(3'd7, 2'd2, 8'h30, 2'd0, 4'h0, 4'h9, 1'b0, "R10", 0);
    run_op(3'd1, 2'd3, 8'h07, 2'd2, 4'h3, 4'h0, 1'b1, "R10", 0);
    run_op(3'd6, 2'd3, 8'h07, 2'd2, 4'h3, 4'h0, 1'b0, "R10", 0);
    run_op(3'd5, 2'd3, 8'h07, 2'd2, 4'h3, 4'h0, 1'b1, "R10", 0);
  endtask

  task automatic t_illegal();
    run_op(3'd0, 2'd0, 8'h77, 2'd0, 4'h0, 4'h0, 1'b0, "R7", 0);
    run_op(3'd4, 2'd0, 8'h77, 2'd0, 4'h0, 4'h0, 1'b0, "R11", 0);
    run_op(3'd5, 2'd0, 8'h77, 2'd1, 4'h0, 4'h0, 1'b1, "R11", 0);
    run_op(3'd6, 2'd0, 8'h77, 2'd0, 4'h0, 4'h0, 1'b0, "R11", 0);
    run_op(3'd7, 2'd0, 8'h77, 2'd0, 4'h0, 4'h0, 1'b1, "R11", 0);
  endtask

  task automatic t_busy();
    logic [3:0] other;
    other = mem[8'hC5];
    run_op(3'd0, 2'd0, 8'h3A, 2'd2, 4'h0, 4'h0, 1'b0, "R2", 1);
    chk("R2", "complement address untouched", int'(mem[8'hC5]), int'(other));
    run_op(3'd2, 2'd0, 8'h3A, 2'd2, 4'h0, 4'h0, 1'b1, "R2", 1);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_skip();
    t_fixed();
    t_lindex();
    t_hindex();
    t_carry();
    t_illegal();
    t_busy();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule